// File: doc/BRIEF.md
# Configurable I/O Pad Cell

This block models one user-configurable input/output cell placed between a bidirectional package pad and the core logic. A set of static configuration inputs chooses its options. The input side offers the live pad level and a stored copy. The storage element can work as an edge-triggered flip-flop or as a level-sensitive latch. The output side offers a direct or registered data path, optional inversion, and a three-state buffer whose control can follow a core signal, with either polarity, or be forced on or off.

All sequential logic runs on one fast system clock `clk`. The edge clock lines arrive as sampled levels. The selected line is XORed with its own per-line inversion bit to give the effective line level. A rising edge of that level is detected by comparing it with its value on the previous `clk` cycle. Drive strength, thresholds and the real pull-up resistor are not modelled. Pull-up and slew state leave the cell only as status outputs. After configuration completes, the first activation of the output runs slew-limited.

Top module: `iocell_top`

## Requirements
- R1: With `cfg_ts_mode` = 2'b00 or 2'b11 and `cfg_ts_inv` = 0, the pad is driven while `t_ctrl` = 0 and floats while `t_ctrl` = 1.
- R2: With `cfg_ts_inv` = 1 in a follow mode, the sense of `t_ctrl` is reversed: 1 drives the pad and 0 floats it.
- R3: `cfg_ts_mode` = 2'b01 keeps the buffer off and 2'b10 keeps it on, whatever the values of `t_ctrl` and `cfg_ts_inv`.
- R4: When the pad is driven, it carries the output data XOR `cfg_out_inv`.
- R5: With `cfg_out_reg` = 0 the output data is `o_data` combinationally. With `cfg_out_reg` = 1 it is a register that loads `o_data` on the clock after the selected output line's effective level rises. Changes on the other line do not affect it.
- R6: Each cell clock is chosen by a select index (`cfg_in_sel`, `cfg_out_sel`) from `edge_clk`. The effective level is `edge_clk[i] ^ cfg_line_inv[i]`, so the inversion applies to the whole line.
- R7: `in_direct` always equals the pad. In flip-flop mode (`cfg_in_latch` = 0), `in_stored` loads the pad on a rising effective input line and holds otherwise. In latch mode it follows the pad, one clock later, while the effective line is low, and holds while the line is high.
- R8: While `rst` = 1 or `config_done` = 0, both storage elements are cleared. While `config_done` = 0, the pad is never driven.
- R9: `pullup_on` = `cfg_pullup_req` AND the buffer is not driving.
- R10: A rising `config_done` sets a soft-start state that forces `slew_limited` = 1. The state clears on the first clock edge at which the buffer drives. Outside the soft-start state, `slew_limited` = NOT `cfg_fast_slew`.
- R11: Feeding the same signal to `o_data` and `t_ctrl` (follow mode, no inversions) yields open-drain behaviour: the pad is driven only to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| config_done | input | 1 | High once configuration has completed |
| edge_clk | input | NUM_LINES | Edge clock line levels |
| cfg_line_inv | input | NUM_LINES | Per-line polarity inversion |
| cfg_in_sel | input | SELW | Input storage line select |
| cfg_out_sel | input | SELW | Output register line select |
| cfg_in_latch | input | 1 | 1 = latch, 0 = flip-flop |
| cfg_out_reg | input | 1 | 1 = registered output |
| cfg_out_inv | input | 1 | Output data inversion |
| cfg_ts_mode | input | 2 | Buffer mode: follow, off, on, follow |
| cfg_ts_inv | input | 1 | Reverse the three-state control sense |
| cfg_fast_slew | input | 1 | 1 = fast slew after soft start |
| cfg_pullup_req | input | 1 | Pull-up requested |
| o_data | input | 1 | Output data from core |
| t_ctrl | input | 1 | Three-state control from core |
| in_direct | output | 1 | Live pad level |
| in_stored | output | 1 | Stored pad level |
| pullup_on | output | 1 | Pull-up active status |
| slew_limited | output | 1 | Slew-limited status |
| pad | inout | 1 | Package pad |

## Verification
On every cycle, the embedded properties check four things. The stored input holds whenever neither a rising edge nor latch transparency loads it. A transparent latch takes the pad value of the previous cycle. The output register takes `o_data` after each effective rising edge. The soft-start state sets on a rising `config_done` and clears after the first driven cycle. Only the bench scenarios can show the combined pad value across every buffer mode, polarity and inversion. The same holds for the immunity to the unselected line, for open-drain use and for the clearing while configuration is incomplete. These scenarios sweep all option combinations against values computed from the requirements.

// File: rtl/iocell_pkg.sv
package iocell_pkg;
  typedef enum logic [1:0] {
    TS_FOLLOW     = 2'b00,
    TS_FLOAT      = 2'b01,
    TS_DRIVE      = 2'b10,
    TS_FOLLOW_ALT = 2'b11
  } ts_mode_e;
endpackage

// File: rtl/iocell_edge.sv
module iocell_edge #(
  parameter int NUM_LINES = 2,
  parameter int SELW      = 1
) (
  input  logic                 clk,
  input  logic [NUM_LINES-1:0] lines,
  input  logic [NUM_LINES-1:0] line_inv,
  input  logic [SELW-1:0]      sel,
  output logic                 eff,
  output logic                 rise
);
  logic prev_q;

  // inversion belongs to the line, so it is applied before selection
  logic [NUM_LINES-1:0] eff_lines;
  assign eff_lines = lines ^ line_inv;
  assign eff       = eff_lines[sel];
  assign rise      = eff & ~prev_q;

  always_ff @(posedge clk) begin
    prev_q <= eff;
  end
endmodule

// File: rtl/iocell_in_store.sv
module iocell_in_store (
  input  logic clk,
  input  logic clr,
  input  logic latch_mode,
  input  logic eff,
  input  logic rise,
  input  logic d,
  output logic q
);
  logic load;
  // same line polarity: FF takes the rising level, latch is open while low
  assign load = latch_mode ? ~eff : rise;

  always_ff @(posedge clk) begin
    if (clr)       q <= 1'b0;
    else if (load) q <= d;
  end

  a_r7_hold_without_load: assert property (@(posedge clk) disable iff (clr)
    (!load) |=> $stable(q));

  a_r7_latch_follows: assert property (@(posedge clk) disable iff (clr)
    (latch_mode && !eff) |=> (q == $past(d)));
endmodule

// File: rtl/iocell_out_path.sv
module iocell_out_path
  import iocell_pkg::*;
(
  input  logic     clk,
  input  logic     clr,
  input  logic     cfg_done,
  input  logic     o_data,
  input  logic     t_ctrl,
  input  logic     reg_mode,
  input  logic     out_inv,
  input  ts_mode_e ts_mode,
  input  logic     ts_inv,
  input  logic     rise,
  output logic     out_val,
  output logic     drive_en
);
  logic q_reg;
  logic t_eff;

  always_ff @(posedge clk) begin
    if (clr)       q_reg <= 1'b0;
    else if (rise) q_reg <= o_data;
  end

  assign out_val = (reg_mode ? q_reg : o_data) ^ out_inv;
  assign t_eff   = t_ctrl ^ ts_inv;

  always_comb begin
    unique case (ts_mode)
      TS_FLOAT: drive_en = 1'b0;
      TS_DRIVE: drive_en = cfg_done;
      default:  drive_en = cfg_done & ~t_eff;
    endcase
  end

  a_r5_reg_capture: assert property (@(posedge clk) disable iff (clr)
    rise |=> (q_reg == $past(o_data)));
endmodule

// File: rtl/iocell_softstart.sv
module iocell_softstart (
  input  logic clk,
  input  logic rst,
  input  logic cfg_done,
  input  logic drive_en,
  input  logic fast_slew,
  output logic slew_limited
);
  logic cd_q;
  logic soft_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cd_q   <= cfg_done;
      soft_q <= 1'b0;
    end else begin
      cd_q <= cfg_done;
      if (cfg_done && !cd_q)  soft_q <= 1'b1;
      else if (drive_en)      soft_q <= 1'b0;
    end
  end

  assign slew_limited = soft_q | ~fast_slew;

  a_r10_soft_set: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_done) |=> soft_q);

  a_r10_soft_clear: assert property (@(posedge clk) disable iff (rst)
    (soft_q && drive_en && !$rose(cfg_done)) |=> !soft_q);
endmodule

// File: rtl/iocell_top.sv
module iocell_top
  import iocell_pkg::*;
#(
  parameter int NUM_LINES = 2,
  localparam int SELW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 config_done,
  input  logic [NUM_LINES-1:0] edge_clk,
  input  logic [NUM_LINES-1:0] cfg_line_inv,
  input  logic [SELW-1:0]      cfg_in_sel,
  input  logic [SELW-1:0]      cfg_out_sel,
  input  logic                 cfg_in_latch,
  input  logic                 cfg_out_reg,
  input  logic                 cfg_out_inv,
  input  logic [1:0]           cfg_ts_mode,
  input  logic                 cfg_ts_inv,
  input  logic                 cfg_fast_slew,
  input  logic                 cfg_pullup_req,
  input  logic                 o_data,
  input  logic                 t_ctrl,
  output logic                 in_direct,
  output logic                 in_stored,
  output logic                 pullup_on,
  output logic                 slew_limited,
  inout  wire                  pad
);
  logic clr;
  logic in_eff, in_rise, out_eff, out_rise;
  logic out_val, drive_en;

  assign clr = rst | ~config_done;

  iocell_edge #(.NUM_LINES(NUM_LINES), .SELW(SELW)) u_in_edge (
    .clk(clk), .lines(edge_clk), .line_inv(cfg_line_inv),
    .sel(cfg_in_sel), .eff(in_eff), .rise(in_rise));

  iocell_edge #(.NUM_LINES(NUM_LINES), .SELW(SELW)) u_out_edge (
    .clk(clk), .lines(edge_clk), .line_inv(cfg_line_inv),
    .sel(cfg_out_sel), .eff(out_eff), .rise(out_rise));

  iocell_in_store u_in_store (
    .clk(clk), .clr(clr), .latch_mode(cfg_in_latch),
    .eff(in_eff), .rise(in_rise), .d(pad), .q(in_stored));

  iocell_out_path u_out_path (
    .clk(clk), .clr(clr), .cfg_done(config_done), .o_data(o_data),
    .t_ctrl(t_ctrl), .reg_mode(cfg_out_reg), .out_inv(cfg_out_inv),
    .ts_mode(ts_mode_e'(cfg_ts_mode)), .ts_inv(cfg_ts_inv),
    .rise(out_rise), .out_val(out_val), .drive_en(drive_en));

  iocell_softstart u_soft (
    .clk(clk), .rst(rst), .cfg_done(config_done), .drive_en(drive_en),
    .fast_slew(cfg_fast_slew), .slew_limited(slew_limited));

  assign pad       = drive_en ? out_val : 1'bz;
  assign in_direct = pad;
  assign pullup_on = cfg_pullup_req & ~drive_en;

  logic unused_eff;
  assign unused_eff = out_eff;
endmodule

// File: tb/tb_iocell_top.sv
module tb_iocell_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic config_done = 1'b0;
  logic [1:0] edge_clk = '0;
  logic [1:0] cfg_line_inv = '0;
  logic [0:0] cfg_in_sel = '0;
  logic [0:0] cfg_out_sel = '0;
  logic cfg_in_latch = 0, cfg_out_reg = 0, cfg_out_inv = 0;
  logic [1:0] cfg_ts_mode = 2'b01;
  logic cfg_ts_inv = 0, cfg_fast_slew = 1, cfg_pullup_req = 1;
  logic o_data = 0, t_ctrl = 1;
  logic in_direct, in_stored, pullup_on, slew_limited;
  logic tb_en = 1'b1, tb_val = 1'b0;
  wire  pad;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  assign pad = tb_en ? tb_val : 1'bz;

  always #(CLK_PERIOD/2) clk = ~clk;

  iocell_top #(.NUM_LINES(2)) dut (
    .clk(clk), .rst(rst), .config_done(config_done), .edge_clk(edge_clk),
    .cfg_line_inv(cfg_line_inv), .cfg_in_sel(cfg_in_sel), .cfg_out_sel(cfg_out_sel),
    .cfg_in_latch(cfg_in_latch), .cfg_out_reg(cfg_out_reg), .cfg_out_inv(cfg_out_inv),
    .cfg_ts_mode(cfg_ts_mode), .cfg_ts_inv(cfg_ts_inv), .cfg_fast_slew(cfg_fast_slew),
    .cfg_pullup_req(cfg_pullup_req), .o_data(o_data), .t_ctrl(t_ctrl),
    .in_direct(in_direct), .in_stored(in_stored), .pullup_on(pullup_on),
    .slew_limited(slew_limited), .pad(pad));

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_eff(input int line, input bit v);
    edge_clk[line] = v ^ cfg_line_inv[line];
  endtask

  task automatic pulse_rst();
    rst = 1'b1;
    tick();
    rst = 1'b0;
  endtask

  function automatic bit exp_drive(input logic [1:0] mode, input bit tinv, input bit t);
    if (mode == 2'b01) return 1'b0;
    if (mode == 2'b10) return 1'b1;
    return (t ^ tinv) == 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    // reset state, configuration incomplete (R8)
    chk("R8 reset stored", in_stored, 1'b0);
    chk("R8 reset pad undriven", pad, 1'b0);
    rst = 1'b0;
    config_done = 1'b1;
    tick();
    tick();
    t_ctrl = 1'b1;

    // output path sweep: R1 R2 R3 R4 R5 R6 R9
    for (int osel = 0; osel < 2; osel++)
    for (int linv = 0; linv < 2; linv++)
    for (int rg = 0; rg < 2; rg++)
    for (int oinv = 0; oinv < 2; oinv++)
    for (int md = 0; md < 4; md++)
    for (int tinv = 0; tinv < 2; tinv++)
    for (int fs = 0; fs < 2; fs++)
    for (int pu = 0; pu < 2; pu++) begin
      cfg_out_sel = osel[0:0];
      cfg_line_inv[osel] = linv[0];
      cfg_line_inv[1-osel] = ~linv[0];
      cfg_out_reg = rg[0]; cfg_out_inv = oinv[0];
      cfg_ts_mode = md[1:0]; cfg_ts_inv = tinv[0];
      cfg_fast_slew = fs[0]; cfg_pullup_req = pu[0];
      set_eff(0, 1'b0); set_eff(1, 1'b0);
      pulse_rst();
      for (int ot = 0; ot < 4; ot++) begin
        bit o, t, drv;
        o = ot[0]; t = ot[1];
        drv = exp_drive(md[1:0], tinv[0], t);
        o_data = o; t_ctrl = t;
        tb_en = ~drv; tb_val = ~o;
        set_eff(osel, 1'b0); set_eff(1-osel, 1'b0);
        tick();
        set_eff(osel, 1'b1);
        tick();
        chk("R1 R2 R3 R4 pad", pad, drv ? (o ^ oinv[0]) : ~o);
        chk("R9 pullup", pullup_on, pu[0] & ~drv);
        chk("R10 slew config", slew_limited, ~fs[0]);
        o_data = ~o;
        set_eff(1-osel, 1'b1);
        tick();
        chk("R5 R6 other line ignored", pad,
            drv ? ((rg[0] ? o : ~o) ^ oinv[0]) : ~o);
      end
    end

    // input path sweep: R6 R7
    cfg_ts_mode = 2'b01;
    tb_en = 1'b1;
    for (int isel = 0; isel < 2; isel++)
    for (int linv = 0; linv < 2; linv++)
    for (int lat = 0; lat < 2; lat++)
    for (int d = 0; d < 8; d++) begin
      cfg_in_sel = isel[0:0];
      cfg_line_inv[isel] = linv[0];
      cfg_line_inv[1-isel] = linv[0];
      cfg_in_latch = lat[0];
      set_eff(0, 1'b1); set_eff(1, 1'b1);
      pulse_rst();
      set_eff(isel, 1'b0); tb_val = d[0];
      tick();
      chk("R7 step1 stored", in_stored, lat[0] ? d[0] : 1'b0);
      chk("R7 direct", in_direct, d[0]);
      set_eff(isel, 1'b1); set_eff(1-isel, 1'b0); tb_val = d[1];
      tick();
      chk("R7 R6 step2 stored", in_stored, lat[0] ? d[0] : d[1]);
      set_eff(1-isel, 1'b1); tb_val = d[2];
      tick();
      chk("R7 R6 step3 hold", in_stored, lat[0] ? d[0] : d[1]);
      chk("R7 direct live", in_direct, d[2]);
    end

    // soft start and configuration clear: R8 R10
    cfg_line_inv = '0; cfg_in_sel = '0; cfg_in_latch = 1'b1;
    cfg_ts_mode = 2'b00; cfg_ts_inv = 1'b0; cfg_out_inv = 1'b0;
    cfg_out_reg = 1'b0; cfg_fast_slew = 1'b1; cfg_pullup_req = 1'b1;
    edge_clk = '0;
    config_done = 1'b0; o_data = 1'b0; t_ctrl = 1'b0;
    tb_en = 1'b1; tb_val = 1'b1;
    pulse_rst();
    tick();
    chk("R8 no drive during config", pad, 1'b1);
    chk("R8 stored cleared during config", in_stored, 1'b0);
    chk("R9 pullup during config", pullup_on, 1'b1);
    t_ctrl = 1'b1;
    config_done = 1'b1;
    tick();
    chk("R10 soft start set", slew_limited, 1'b1);
    tick();
    chk("R10 soft start held", slew_limited, 1'b1);
    t_ctrl = 1'b0; tb_en = 1'b0;
    #1;
    chk("R10 first activation limited", slew_limited, 1'b1);
    chk("R1 driven low", pad, 1'b0);
    tick();
    chk("R10 soft start cleared", slew_limited, 1'b0);
    t_ctrl = 1'b1; tb_en = 1'b1; tb_val = 1'b0;
    tick();
    t_ctrl = 1'b0; tb_en = 1'b0;
    tick();
    chk("R10 no second soft start", slew_limited, 1'b0);
    cfg_fast_slew = 1'b0;
    #1;
    chk("R10 configured slow", slew_limited, 1'b1);
    o_data = 1'b1;
    tick();
    tick();
    chk("R7 latch captured driven pad", in_stored, 1'b1);
    rst = 1'b1;
    tick();
    chk("R8 reset clears stored", in_stored, 1'b0);
    rst = 1'b0;
    config_done = 1'b0; tb_en = 1'b1; tb_val = 1'b0;
    #1;
    chk("R8 drive removed", pad, 1'b0);
    config_done = 1'b1;
    tick();

    // open drain: R11
    cfg_ts_mode = 2'b00; cfg_ts_inv = 1'b0; cfg_out_inv = 1'b0; cfg_out_reg = 1'b0;
    for (int v = 0; v < 2; v++) begin
      o_data = v[0]; t_ctrl = v[0];
      tb_en = v[0]; tb_val = 1'b1;
      tick();
      chk("R11 open drain pad", pad, v[0]);
      chk("R11 pullup when released", pullup_on, v[0]);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule